// File: doc/BRIEF.md
# GPU Command Packet Parser

This block sits on the rendering command port of a graphics engine. Command words arrive one at a time on a valid/ready interface. The parser reads the top byte of each header word and sorts it into one of four classes: a primitive that needs a packet, a state command, a fill request, or a code it does not know. For a polygon header it works out the packet length from the header's own flag bits (vertex count, texturing, shading). It gathers the parameter words that follow and then presents the whole packet at once, with a strobe, to the rasteriser downstream.

Four state commands are not forwarded. They land in local registers: the draw-mode fields, the two corners of the clipping rectangle, and the drawing offset. The rasteriser reads these registers directly. A word with an unknown code is taken in and thrown away, and the next word is treated as a fresh header. While a finished packet waits for the consumer, the input stalls, so no word is lost.

Top module: `gpu_cmd_parser`

## Requirements
- R1: After reset is asserted, `in_ready` is 1, `pkt_valid` is 0, and `draw_mode`, `area_x1`, `area_y1`, `area_x2`, `area_y2`, `offs_x` and `offs_y` are all 0.
- R2: A header word with bits 31:29 equal to 001 is a polygon (`pkt_kind` = 1). A header with code 02h in bits 31:24 is a rectangle fill of exactly three words (`pkt_kind` = 0, `pkt_len` = 3).
- R3: A polygon header sets the packet length. Bit 27 selects 4 vertices (1) or 3 (0). Each vertex takes 1 word, or 2 words if bit 26 (textured) is set. If bit 28 (Gouraud) is set, one extra colour word is added for every vertex after the first. The header itself counts as one word.
- R4: In the cycle after the final word of a packet is accepted, `pkt_valid` rises. Packet word i appears on `pkt_data[32*i+31:32*i]`, with the header as word 0. `pkt_len` gives the number of meaningful words. `pkt_valid` stays 0 while a packet is only partly collected.
- R5: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_data`, `pkt_len` and `pkt_kind` hold their values and `in_ready` is 0. Words offered on the input during this time are not taken and change no state.
- R6: If `pkt_valid` and `pkt_ready` are both 1 in a cycle, then in the next cycle `pkt_valid` is 0 and `in_ready` is 1.
- R7: Accepting a header with code E1h loads bits 10:0 of that word into `draw_mode`, and the new value is visible in the next cycle. The fields are: 3:0 texture page X base, 4 texture page Y base, 6:5 blend mode, 8:7 texel depth, 9 dither enable, 10 display-area drawing allowed.
- R8: A header with code E3h loads `area_x1` from bits 9:0 and `area_y1` from bits 18:10. A header with code E4h loads `area_x2` and `area_y2` from the same fields.
- R9: A header with code E5h loads `offs_x` from bits 9:0 and `offs_y` from bits 18:10.
- R10: Any other header code is accepted as a single word and dropped. It changes no register and produces no packet, and the following word is decoded as a new header.
- R11: Parameter words inside a packet are stored as data and never decoded. A parameter word whose top byte is E1h does not change `draw_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser can take a word |
| pkt_valid | output | 1 | Completed packet presented |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_kind | output | 1 | 0 = rectangle fill, 1 = polygon |
| pkt_len | output | 4 | Number of valid packet words |
| pkt_data | output | 384 | Packet words, word i at bits 32i+31:32i |
| draw_mode | output | 11 | Stored draw-mode fields |
| area_x1 | output | 10 | Clip rectangle left |
| area_y1 | output | 9 | Clip rectangle top |
| area_x2 | output | 10 | Clip rectangle right |
| area_y2 | output | 9 | Clip rectangle bottom |
| offs_x | output | 10 | Drawing offset X |
| offs_y | output | 9 | Drawing offset Y |

## Verification
The checker watches the output handshake on every cycle. It confirms that a waiting packet stays frozen and stalls the input, and that a handoff clears the strobe. For any presented packet it checks that the length matches the packet's kind and its header flags. It also checks that the draw-mode and offset registers move only in the cycle after their own command code is accepted. The bench scenarios are needed for the rest. Only they can show that the word order inside a packet is preserved, that an unknown code consumes exactly one word, and that a command code appearing inside a parameter word is never decoded. Their expected values come from a model of the register contents and of the packet lengths.

// File: rtl/gpu_pkt_pkg.sv
package gpu_pkt_pkg;

  typedef enum logic [1:0] {
    CLS_DROP  = 2'd0,
    CLS_FILL  = 2'd1,
    CLS_POLY  = 2'd2,
    CLS_STATE = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_BODY = 2'd1,
    ST_OUT  = 2'd2
  } parse_state_e;

  localparam logic [7:0] OP_FILL    = 8'h02;
  localparam logic [7:0] OP_MODE    = 8'hE1;
  localparam logic [7:0] OP_AREA_TL = 8'hE3;
  localparam logic [7:0] OP_AREA_BR = 8'hE4;
  localparam logic [7:0] OP_OFFSET  = 8'hE5;

  localparam logic PKT_FILL = 1'b0;
  localparam logic PKT_POLY = 1'b1;

endpackage

// File: rtl/gpu_hdr_decode.sv
module gpu_hdr_decode
  import gpu_pkt_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       op,
  output cmd_class_e       cls,
  output logic [LEN_W-1:0] len
);

  logic [LEN_W-1:0] verts;
  logic [LEN_W-1:0] per_vert;
  logic [LEN_W-1:0] shade_extra;

  // length built from the flag bits: vertex count, texture, shading
  always_comb begin
    verts       = op[3] ? LEN_W'(4) : LEN_W'(3);
    per_vert    = op[2] ? LEN_W'(2) : LEN_W'(1);
    shade_extra = op[4] ? (verts - LEN_W'(1)) : '0;
    len         = LEN_W'(1) + LEN_W'(verts * per_vert) + shade_extra;
  end

  always_comb begin
    if (op[7:5] == 3'b001) begin
      cls = CLS_POLY;
    end else if (op == OP_FILL) begin
      cls = CLS_FILL;
    end else if (op == OP_MODE || op == OP_AREA_TL ||
                 op == OP_AREA_BR || op == OP_OFFSET) begin
      cls = CLS_STATE;
    end else begin
      cls = CLS_DROP;
    end
  end

endmodule

// File: rtl/gpu_state_regs.sv
module gpu_state_regs
  import gpu_pkt_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 9,
  parameter int MODE_W = 11,
  localparam int P_W   = X_W + Y_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        op,
  input  logic [P_W-1:0]    param,
  output logic [MODE_W-1:0] draw_mode,
  output logic [X_W-1:0]    area_x1,
  output logic [Y_W-1:0]    area_y1,
  output logic [X_W-1:0]    area_x2,
  output logic [Y_W-1:0]    area_y2,
  output logic [X_W-1:0]    offs_x,
  output logic [Y_W-1:0]    offs_y
);

  logic mode_en, tl_en, br_en, offs_en;
  logic [X_W-1:0] px;
  logic [Y_W-1:0] py;

  always_comb begin
    mode_en = wr_en && (op == OP_MODE);
    tl_en   = wr_en && (op == OP_AREA_TL);
    br_en   = wr_en && (op == OP_AREA_BR);
    offs_en = wr_en && (op == OP_OFFSET);
    px      = param[X_W-1:0];
    py      = param[P_W-1:X_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draw_mode <= '0;
    end else if (mode_en) begin
      draw_mode <= param[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_x1 <= '0;
      area_y1 <= '0;
    end else if (tl_en) begin
      area_x1 <= px;
      area_y1 <= py;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_x2 <= '0;
      area_y2 <= '0;
    end else if (br_en) begin
      area_x2 <= px;
      area_y2 <= py;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_x <= '0;
      offs_y <= '0;
    end else if (offs_en) begin
      offs_x <= px;
      offs_y <= py;
    end
  end

endmodule

// File: rtl/gpu_pkt_buffer.sv
module gpu_pkt_buffer #(
  parameter int MAX_WORDS = 12,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [MAX_WORDS*WORD_W-1:0] words
);

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    logic slot_en;
    logic [WORD_W-1:0] slot_q;

    always_comb slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign words[g*WORD_W +: WORD_W] = slot_q;
  end

endmodule

// File: rtl/gpu_cmd_parser.sv
module gpu_cmd_parser
  import gpu_pkt_pkg::*;
#(
  parameter int MAX_WORDS = 12,
  parameter int X_W       = 10,
  parameter int Y_W       = 9,
  parameter int MODE_W    = 11,
  localparam int WORD_W   = 32,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        in_ready,
  output logic                        pkt_valid,
  input  logic                        pkt_ready,
  output logic                        pkt_kind,
  output logic [CNT_W-1:0]            pkt_len,
  output logic [MAX_WORDS*WORD_W-1:0] pkt_data,
  output logic [MODE_W-1:0]           draw_mode,
  output logic [X_W-1:0]              area_x1,
  output logic [Y_W-1:0]              area_y1,
  output logic [X_W-1:0]              area_x2,
  output logic [Y_W-1:0]              area_y2,
  output logic [X_W-1:0]              offs_x,
  output logic [Y_W-1:0]              offs_y
);

  parse_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] len_q, len_d;
  logic             kind_q, kind_d;
  logic             accept;
  logic             buf_wr;
  logic [CNT_W-1:0] buf_idx;
  logic             st_wr;
  cmd_class_e       hdr_cls;
  logic [CNT_W-1:0] hdr_len;

  gpu_hdr_decode #(.LEN_W(CNT_W)) u_dec (
    .op  (in_data[31:24]),
    .cls (hdr_cls),
    .len (hdr_len)
  );

  gpu_state_regs #(.X_W(X_W), .Y_W(Y_W), .MODE_W(MODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_wr),
    .op        (in_data[31:24]),
    .param     (in_data[X_W+Y_W-1:0]),
    .draw_mode (draw_mode),
    .area_x1   (area_x1),
    .area_y1   (area_y1),
    .area_x2   (area_x2),
    .area_y2   (area_y2),
    .offs_x    (offs_x),
    .offs_y    (offs_y)
  );

  gpu_pkt_buffer #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W), .IDX_W(CNT_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_idx  (buf_idx),
    .wr_data (in_data),
    .words   (pkt_data)
  );

  always_comb begin
    in_ready = (state_q != ST_OUT);
    accept   = in_valid && in_ready;
    cnt_inc  = cnt_q + CNT_W'(1);
    state_d  = state_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    kind_d   = kind_q;
    buf_wr   = 1'b0;
    buf_idx  = cnt_q;
    st_wr    = 1'b0;
    case (state_q)
      ST_HDR: begin
        if (accept) begin
          buf_idx = '0;
          case (hdr_cls)
            CLS_FILL: begin
              buf_wr  = 1'b1;
              len_d   = CNT_W'(3);
              kind_d  = PKT_FILL;
              cnt_d   = CNT_W'(1);
              state_d = ST_BODY;
            end
            CLS_POLY: begin
              buf_wr  = 1'b1;
              len_d   = hdr_len;
              kind_d  = PKT_POLY;
              cnt_d   = CNT_W'(1);
              state_d = ST_BODY;
            end
            CLS_STATE: st_wr = 1'b1;
            default:   ;
          endcase
        end
      end
      ST_BODY: begin
        if (accept) begin
          buf_wr = 1'b1;
          cnt_d  = cnt_inc;
          if (cnt_inc == len_q) begin
            state_d = ST_OUT;
          end
        end
      end
      ST_OUT: begin
        if (pkt_ready) begin
          state_d = ST_HDR;
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      len_q   <= '0;
      kind_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      kind_q  <= kind_d;
    end
  end

  assign pkt_valid = (state_q == ST_OUT);
  assign pkt_kind  = kind_q;
  assign pkt_len   = len_q;

endmodule

// File: rtl/gpu_cmd_parser_chk.sv
module gpu_cmd_parser_chk #(
  parameter int MAX_WORDS = 12,
  parameter int CNT_W     = 4,
  parameter int X_W       = 10,
  parameter int Y_W       = 9,
  parameter int MODE_W    = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [7:0]              in_op,
  input logic                    in_ready,
  input logic                    pkt_valid,
  input logic                    pkt_ready,
  input logic                    pkt_kind,
  input logic [CNT_W-1:0]        pkt_len,
  input logic [MAX_WORDS*32-1:0] pkt_data,
  input logic [MODE_W-1:0]       draw_mode,
  input logic [X_W-1:0]          offs_x,
  input logic [Y_W-1:0]          offs_y
);

  function automatic logic [CNT_W-1:0] flag_len(input logic [7:0] op);
    int nv;
    int n;
    nv = op[3] ? 4 : 3;
    n  = 1 + nv * (op[2] ? 2 : 1) + (op[4] ? nv - 1 : 0);
    return CNT_W'(n);
  endfunction

  logic took;
  assign took = in_valid && in_ready;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_len) && $stable(pkt_kind));

  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready |=> !pkt_valid && in_ready);

  // R2
  fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_kind |-> pkt_len == CNT_W'(3) && pkt_data[31:24] == 8'h02);

  // R3
  poly_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_kind |-> pkt_data[31:29] == 3'b001 && pkt_len == flag_len(pkt_data[31:24]));

  // R7
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(took && in_op == 8'hE1) |=> $stable(draw_mode));

  // R9
  offs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(took && in_op == 8'hE5) |=> $stable(offs_x) && $stable(offs_y));

endmodule

bind gpu_cmd_parser gpu_cmd_parser_chk #(
  .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .X_W(X_W), .Y_W(Y_W), .MODE_W(MODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_data[31:24]),
  .in_ready  (in_ready),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_kind  (pkt_kind),
  .pkt_len   (pkt_len),
  .pkt_data  (pkt_data),
  .draw_mode (draw_mode),
  .offs_x    (offs_x),
  .offs_y    (offs_y)
);

// File: tb/gpu_cmd_parser_bench.sv
module gpu_cmd_parser_bench;
  localparam int MW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, pkt_ready;
  logic [31:0] in_data;
  logic in_ready, pkt_valid, pkt_kind;
  logic [3:0] pkt_len;
  logic [MW*32-1:0] pkt_data;
  logic [10:0] draw_mode;
  logic [9:0] area_x1, area_x2, offs_x;
  logic [8:0] area_y1, area_y2, offs_y;

  always #10 clk = ~clk;

  gpu_cmd_parser u_gpu_cmd_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_kind(pkt_kind), .pkt_len(pkt_len), .pkt_data(pkt_data),
    .draw_mode(draw_mode), .area_x1(area_x1), .area_y1(area_y1),
    .area_x2(area_x2), .area_y2(area_y2), .offs_x(offs_x), .offs_y(offs_y)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_w [MW];
  logic [10:0] m_mode;
  logic [9:0] m_x1, m_x2, m_ox;
  logic [8:0] m_y1, m_y2, m_oy;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int poly_len(input logic [7:0] op);
    int nv;
    nv = op[3] ? 4 : 3;
    return 1 + nv * (op[2] ? 2 : 1) + (op[4] ? nv - 1 : 0);
  endfunction

  task automatic send(input logic [31:0] w);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom;
  endtask

  task automatic check_state(input string req);
    chk(req, "draw_mode", 64'(draw_mode), 64'(m_mode));
    chk(req, "area_tl", 64'({area_x1, area_y1}), 64'({m_x1, m_y1}));
    chk(req, "area_br", 64'({area_x2, area_y2}), 64'({m_x2, m_y2}));
    chk(req, "offset", 64'({offs_x, offs_y}), 64'({m_ox, m_oy}));
  endtask

  // state command: update the model from the R7/R8/R9 field positions
  task automatic state_cmd(input logic [31:0] w, input string req);
    send(w);
    case (w[31:24])
      8'hE1: m_mode = w[10:0];
      8'hE3: begin m_x1 = w[9:0]; m_y1 = w[18:10]; end
      8'hE4: begin m_x2 = w[9:0]; m_y2 = w[18:10]; end
      8'hE5: begin m_ox = w[9:0]; m_oy = w[18:10]; end
      default: ;
    endcase
    check_state(req);
    chk(req, "no packet", 64'(pkt_valid), 64'd0);
  endtask

  task automatic drop_cmd(input logic [31:0] w);
    send(w);
    chk("R10", "no packet after unknown", 64'(pkt_valid), 64'd0);
    chk("R10", "ready after unknown", 64'(in_ready), 64'd1);
    check_state("R10");
  endtask

  task automatic run_pkt(input int n, input logic kind, input int hold);
    for (int i = 0; i < n; i++) begin
      send(exp_w[i]);
      if (i < n - 1) chk("R4", "no early strobe", 64'(pkt_valid), 64'd0);
    end
    chk("R4", "strobe", 64'(pkt_valid), 64'd1);
    chk(kind ? "R3" : "R2", "length", 64'(pkt_len), 64'(n));
    chk("R2", "kind", 64'(pkt_kind), 64'(kind));
    for (int i = 0; i < n; i++) chk("R4", "word", 64'(pkt_data[i*32 +: 32]), 64'(exp_w[i]));
    for (int k = 0; k < hold; k++) begin
      in_valid = 1'b1;
      in_data  = {8'hE1, 24'($urandom)};
      @(negedge clk);
      chk("R5", "held strobe", 64'(pkt_valid), 64'd1);
      chk("R5", "stalled", 64'(in_ready), 64'd0);
      chk("R5", "held header", 64'(pkt_data[31:0]), 64'(exp_w[0]));
    end
    in_valid  = 1'b0;
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk("R6", "strobe cleared", 64'(pkt_valid), 64'd0);
    chk("R6", "ready back", 64'(in_ready), 64'd1);
    check_state("R5");
  endtask

  task automatic make_poly(input logic [4:0] flags, output int n);
    exp_w[0] = {3'b001, flags, 24'($urandom)};
    n = poly_len(exp_w[0][31:24]);
    for (int i = 1; i < n; i++) exp_w[i] = $urandom;
  endtask

  task automatic make_fill(output int n);
    exp_w[0] = {8'h02, 24'($urandom)};
    exp_w[1] = $urandom;
    exp_w[2] = $urandom;
    n = 3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] op;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; pkt_ready = 1'b0; in_data = '0;
    {m_mode, m_x1, m_y1, m_x2, m_y2, m_ox, m_oy} = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ready", 64'(in_ready), 64'd1);
    chk("R1", "strobe", 64'(pkt_valid), 64'd0);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // directed state commands, back to back
    state_cmd(32'hE1_0007FF, "R7");
    state_cmd(32'hE1_FFF2A5, "R7");
    state_cmd({8'hE3, 5'h1F, 9'd17, 10'd33}, "R8");
    state_cmd({8'hE4, 5'h00, 9'd239, 10'd320}, "R8");
    state_cmd({8'hE5, 5'h00, 9'd511, 10'd1023}, "R9");

    // fill packet
    make_fill(n);
    run_pkt(n, 1'b0, 2);

    // longest polygon: gouraud textured quad = 12 words; shortest: flat triangle = 4
    make_poly(5'b11100, n);
    chk("R3", "gouraud textured quad model", 64'(n), 64'd12);
    run_pkt(n, 1'b1, 3);
    make_poly(5'b00000, n);
    chk("R3", "flat triangle model", 64'(n), 64'd4);
    run_pkt(n, 1'b1, 0);

    // R11: parameter word with an E1 code stays data
    make_poly(5'b01000, n);
    exp_w[1] = 32'hE1_000123;
    exp_w[2] = 32'hE5_0003FF;
    run_pkt(n, 1'b1, 1);
    chk("R11", "mode untouched", 64'(draw_mode), 64'(m_mode));

    // R10: unknown codes dropped, next word is a header
    drop_cmd(32'h00_000000);
    drop_cmd(32'hE2_ABCDEF);
    drop_cmd(32'h1F_FFFFFF);
    make_fill(n);
    run_pkt(n, 1'b0, 0);

    // random mix
    for (int t = 0; t < 150; t++) begin
      case ($urandom % 4)
        0: begin make_poly(5'($urandom), n); run_pkt(n, 1'b1, $urandom % 4); end
        1: begin make_fill(n); run_pkt(n, 1'b0, $urandom % 3); end
        2: begin
          case ($urandom % 4)
            0: op = 8'hE1;
            1: op = 8'hE3;
            2: op = 8'hE4;
            default: op = 8'hE5;
          endcase
          state_cmd({op, 24'($urandom)}, op == 8'hE1 ? "R7" : (op == 8'hE5 ? "R9" : "R8"));
        end
        default: begin
          op = 8'($urandom);
          while (op[7:5] == 3'b001 || op == 8'h02 || op == 8'hE1 ||
                 op == 8'hE3 || op == 8'hE4 || op == 8'hE5) op = 8'($urandom);
          drop_cmd({op, 24'($urandom)});
        end
      endcase
    end
    finish_run();
  end

endmodule